// File: doc/BRIEF.md
# Byte-Addressed Serial-Bus Memory Target Bank

This block models a bank of small serial-bus memory targets at the transaction level. A host controller gives it one request per cycle. Each request carries a 7-bit target address, a direction bit, a 3-bit protocol code, a command byte and a data byte. The bank holds `NUM_DEV` targets. They sit at consecutive addresses starting at `BASE_ADDR`, which is 0x50 by default, and each owns a private region of 256 bytes.

Each target keeps a current-offset pointer. A send-byte request loads the pointer. Each receive-byte request then streams out the next byte from the pointer. Addressed byte reads and byte writes use the command byte as the location and leave the pointer alone.

The bank answers every request exactly one cycle later with a response strobe, an acknowledge flag and a data byte. The host treats a missing acknowledge as an error. A request gets no acknowledge if it uses an unsupported protocol (word or block) or if no target in the bank holds its address. Such a request leaves all memory and all pointers unchanged.

Top module: `smbus_eeprom_bank`

## Requirements
- R1: Every cycle with `req_valid` high is followed in the next cycle by `rsp_valid` high. In a cycle after one without a request, `rsp_valid` and `rsp_ack` are low. `rsp_ack` is never high while `rsp_valid` is low.
- R2: A request to an address from `BASE_ADDR` to `BASE_ADDR+NUM_DEV-1` reaches target `addr-BASE_ADDR`. A request to any other address is not acknowledged.
- R3: The protocol codes are: 0 for quick, 1 for send-byte or receive-byte, and 2 for write-byte or read-byte. `req_read` selects the read form. Codes 3 to 7 (word, block and unused) are not acknowledged and change no memory or pointer.
- R4: A write-byte request stores `req_data` at location `req_cmd` of the addressed target only.
- R5: A read-byte request returns the byte at location `req_cmd` of the addressed target on `rsp_data`.
- R6: A send-byte request loads the addressed target's pointer with `req_cmd`.
- R7: A receive-byte request returns the byte at the target's pointer and then increments the pointer. The pointer wraps from 0xFF to 0x00.
- R8: Every pointer is 0 after reset. Reset does not clear memory contents.
- R9: A quick request is acknowledged in either direction and changes no memory or pointer.
- R10: Byte reads and byte writes leave the pointer unchanged. Each target's pointer is independent of the others.
- R11: `rsp_data` is 0 on any response that is not an acknowledged read-byte or receive-byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 7 | Target address |
| req_read | input | 1 | 1 = read form of the protocol |
| req_proto | input | 3 | Protocol code |
| req_cmd | input | 8 | Command byte (location, or new pointer) |
| req_data | input | 8 | Data byte for write-byte |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_ack | output | 1 | Request acknowledged |
| rsp_data | output | 8 | Returned byte |

## Verification
The bench first writes every location of all eight targets with a distinct arithmetic pattern. It then reads all of them back with byte reads. This separates the regions from one another and catches any wrong location or target decode.

Pointer streaming is then tried in several situations:
- starting from the reset value;
- after a send-byte to 0xFE, which forces the wrap to 0x00;
- across quick requests and byte accesses placed between the receives;
- on one target while another target's pointer is moved.

Together these show that only send-byte and receive-byte move the pointer, and that each target has its own. A sweep of every rejected protocol code and of the addresses just outside the window checks each response for a missing acknowledge. A read-back afterwards shows that none of those requests changed memory.

// File: rtl/smbus_eeprom_bank.sv
module smbus_eeprom_bank #(
  parameter logic [6:0] BASE_ADDR = 7'h50,
  parameter int         NUM_DEV   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [6:0] req_addr,
  input  logic       req_read,
  input  logic [2:0] req_proto,
  input  logic [7:0] req_cmd,
  input  logic [7:0] req_data,
  output logic       rsp_valid,
  output logic       rsp_ack,
  output logic [7:0] rsp_data
);
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam int WORDS = (1 << DEV_W) * 256;

  logic [7:0] mem [WORDS];
  logic [7:0] ptr [NUM_DEV];

  wire [7:0]       rel      = {1'b0, req_addr} - {1'b0, BASE_ADDR};
  wire             hit      = ({1'b0, req_addr} >= {1'b0, BASE_ADDR}) && (rel < 8'(NUM_DEV));
  wire [DEV_W-1:0] dev      = rel[DEV_W-1:0];
  wire             proto_ok = req_proto <= 3'd2;
  wire             accept   = req_valid && hit && proto_ok;
  wire             stream   = req_proto == 3'd1;

  logic [7:0] cur_ptr;
  always_comb begin
    cur_ptr = 8'h00;
    for (int i = 0; i < NUM_DEV; i++)
      if (dev == DEV_W'(i)) cur_ptr = ptr[i];
  end

  wire [7:0]       byte_idx = stream ? cur_ptr : req_cmd;
  wire [DEV_W+7:0] mem_idx  = {dev, byte_idx};

  wire do_wr   = accept && !req_read && (req_proto == 3'd2);
  wire do_rd   = accept && req_read && (req_proto != 3'd0);
  wire set_ptr = accept && !req_read && stream;
  wire inc_ptr = accept && req_read && stream;

  always_ff @(posedge clk)
    if (do_wr) mem[mem_idx] <= req_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ack   <= 1'b0;
      rsp_data  <= 8'h00;
      for (int i = 0; i < NUM_DEV; i++) ptr[i] <= 8'h00;
    end else begin
      rsp_valid <= req_valid;
      rsp_ack   <= accept;
      rsp_data  <= do_rd ? mem[mem_idx] : 8'h00;
      for (int i = 0; i < NUM_DEV; i++) begin
        if (dev == DEV_W'(i)) begin
          if (set_ptr)      ptr[i] <= req_cmd;
          else if (inc_ptr) ptr[i] <= ptr[i] + 8'd1;
        end
      end
    end
  end
endmodule

// File: rtl/smbus_eeprom_bank_chk.sv
module smbus_eeprom_bank_chk #(
  parameter logic [6:0] BASE_ADDR = 7'h50,
  parameter int         NUM_DEV   = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [6:0] req_addr,
  input logic       req_read,
  input logic [2:0] req_proto,
  input logic       rsp_valid,
  input logic       rsp_ack,
  input logic [7:0] rsp_data
);
  wire [7:0] a8      = {1'b0, req_addr};
  wire [7:0] lo8     = {1'b0, BASE_ADDR};
  wire       outside = (a8 < lo8) || (a8 >= lo8 + 8'(NUM_DEV));

  a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_ack);
  a_r1_ack_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |-> rsp_valid);
  a_r2_outside_nack: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && outside |=> rsp_valid && !rsp_ack);
  a_r3_bad_proto_nack: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_proto > 3'd2) |=> rsp_valid && !rsp_ack);
  a_r9_quick_acked: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !outside && (req_proto == 3'd0) |=> rsp_ack && (rsp_data == 8'h00));
  a_r11_nack_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_ack |-> rsp_data == 8'h00);
  a_r11_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_read |=> rsp_data == 8'h00);
endmodule

bind smbus_eeprom_bank smbus_eeprom_bank_chk #(.BASE_ADDR(BASE_ADDR), .NUM_DEV(NUM_DEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_read(req_read), .req_proto(req_proto), .rsp_valid(rsp_valid),
  .rsp_ack(rsp_ack), .rsp_data(rsp_data)
);

// File: tb/smbus_eeprom_bank_bench.sv
`timescale 1ns/1ps
module smbus_eeprom_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [6:0] req_addr = '0;
  logic       req_read = 1'b0;
  logic [2:0] req_proto = '0;
  logic [7:0] req_cmd = '0;
  logic [7:0] req_data = '0;
  logic       rsp_valid, rsp_ack;
  logic [7:0] rsp_data;
  int total = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  smbus_eeprom_bank u_smbus_eeprom_bank (.*);

  function automatic logic [7:0] pat(int d, int i);
    return 8'(d * 37 + i * 11 + 5);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic xact(input logic [6:0] a, input logic rd, input logic [2:0] pr,
                      input logic [7:0] cmd, input logic [7:0] dat,
                      output logic ack, output logic [7:0] rdat);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_read = rd; req_proto = pr;
    req_cmd = cmd; req_data = dat;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid, "R1", rsp_valid, 1);
    ack = rsp_ack; rdat = rsp_data;
  endtask

  task automatic expect_rd(input logic [6:0] a, input logic [2:0] pr, input logic [7:0] cmd,
                           input logic [7:0] exp, string req);
    logic ack; logic [7:0] d;
    xact(a, 1'b1, pr, cmd, 8'h00, ack, d);
    chk(ack && d == exp, req, {ack, d}, {1'b1, exp});
  endtask

  task automatic expect_nack(input logic [6:0] a, input logic rd, input logic [2:0] pr,
                             input logic [7:0] cmd, input logic [7:0] dat, string req);
    logic ack; logic [7:0] d;
    xact(a, rd, pr, cmd, dat, ack, d);
    chk(!ack && d == 8'h00, req, {ack, d}, 0);
  endtask

  initial begin
    logic ack; logic [7:0] d;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !rsp_ack && rsp_data == 0, "R1 reset", {rsp_valid, rsp_ack}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid, "R1 idle", rsp_valid, 0);

    for (int dv = 0; dv < 8; dv++)
      for (int i = 0; i < 256; i++) begin
        xact(7'(8'h50 + dv), 1'b0, 3'd2, 8'(i), pat(dv, i), ack, d);
        chk(ack && d == 0, "R4 R11 write ack", {ack, d}, 9'h100);
      end
    for (int dv = 0; dv < 8; dv++)
      for (int i = 0; i < 256; i++)
        expect_rd(7'(8'h50 + dv), 3'd2, 8'(i), pat(dv, i), "R5 R2 read-byte");

    for (int dv = 0; dv < 8; dv++)
      expect_rd(7'(8'h50 + dv), 3'd1, 8'h00, pat(dv, 0), "R8 initial pointer");

    xact(7'h55, 1'b0, 3'd1, 8'hFE, 8'h00, ack, d);
    chk(ack && d == 0, "R6 send ack", {ack, d}, 9'h100);
    expect_rd(7'h55, 3'd1, 8'h00, pat(5, 254), "R7 stream 0xFE");
    expect_rd(7'h55, 3'd1, 8'h00, pat(5, 255), "R7 stream 0xFF");
    expect_rd(7'h55, 3'd1, 8'h00, pat(5, 0), "R7 wrap");
    xact(7'h55, 1'b0, 3'd0, 8'h33, 8'h44, ack, d);
    chk(ack && d == 0, "R9 quick write", {ack, d}, 9'h100);
    xact(7'h55, 1'b1, 3'd0, 8'h33, 8'h44, ack, d);
    chk(ack && d == 0, "R9 quick read", {ack, d}, 9'h100);
    expect_rd(7'h55, 3'd1, 8'h00, pat(5, 1), "R9 pointer kept");
    expect_rd(7'h55, 3'd2, 8'h80, pat(5, 128), "R10 read-byte");
    xact(7'h55, 1'b0, 3'd2, 8'h90, pat(5, 144), ack, d);
    expect_rd(7'h55, 3'd1, 8'h00, pat(5, 2), "R10 pointer after byte ops");
    xact(7'h52, 1'b0, 3'd1, 8'h10, 8'h00, ack, d);
    expect_rd(7'h55, 3'd1, 8'h00, pat(5, 3), "R10 independent pointer");
    expect_rd(7'h52, 3'd1, 8'h00, pat(2, 16), "R6 loaded pointer");

    for (int p = 3; p < 8; p++) begin
      expect_nack(7'h50, 1'b0, 3'(p), 8'h20, 8'hEE, "R3 reject write");
      expect_nack(7'h50, 1'b1, 3'(p), 8'h20, 8'hEE, "R3 reject read");
      expect_nack(7'h50, 1'b0, 3'(p), 8'h77, 8'hEE, "R3 reject send");
    end
    expect_rd(7'h50, 3'd2, 8'h20, pat(0, 32), "R3 memory kept");
    expect_rd(7'h50, 3'd1, 8'h00, pat(0, 1), "R3 pointer kept");
    expect_nack(7'h4F, 1'b0, 3'd2, 8'h05, 8'hEE, "R2 below window");
    expect_nack(7'h58, 1'b0, 3'd2, 8'h05, 8'hEE, "R2 above window");
    expect_nack(7'h00, 1'b1, 3'd2, 8'h05, 8'h00, "R2 low address");
    expect_nack(7'h7F, 1'b0, 3'd1, 8'h05, 8'h00, "R2 high address");
    expect_nack(7'h58, 1'b1, 3'd0, 8'h05, 8'h00, "R2 quick outside");
    expect_rd(7'h57, 3'd2, 8'h05, pat(7, 5), "R2 top target untouched");
    expect_rd(7'h50, 3'd2, 8'h05, pat(0, 5), "R2 base target untouched");

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    expect_rd(7'h55, 3'd1, 8'h00, pat(5, 0), "R8 pointer reset");
    expect_rd(7'h52, 3'd1, 8'h00, pat(2, 0), "R8 pointer reset");
    expect_rd(7'h53, 3'd2, 8'h44, pat(3, 68), "R8 memory kept");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule